// File: doc/BRIEF.md
# Transactional Write-Buffer Cache

This block is a small, fully associative array that holds the speculative data of one hardware transaction beside the regular data cache. The processor issues transactional loads and stores to it. A transactional access to a line that the array does not hold allocates two entries. One holds the line's value from before the transaction and is tagged XCOMMIT, meaning it is dropped on commit. The other holds the working value and is tagged XABORT, meaning it is dropped on abort. Stores change only the working copy. Memory is never written by a store.

A commit strobe or an abort strobe retags every entry in the same clock, and no data moves. After a commit, the working copies become ordinary resident lines (NORMAL). After an abort, the saved old values become NORMAL. Dirty resident lines reach memory only later, when the replacement logic evicts them. The array reads a missing line from a simple memory model in the same cycle as the request, and writes back up to two evicted lines per cycle. When the array has no room for a new pair, it raises an overflow and aborts the transaction by itself.

Top module: `txc_cache`

## Requirements
- R1: After synchronous reset every entry is EMPTY, and `rsp_valid`, `overflow` and both `wb_valid` bits are 0.
- R2: `req_op` 0 and 1 are transactional loads and behave identically. On a miss the line is read from memory through `mem_rd_*` in the request cycle. `rsp_valid`/`rsp_data` return the value one cycle later. A clean XCOMMIT entry and an XABORT entry are allocated. `req_op` 3 is ignored.
- R3: `req_op` 2 is a transactional store. It writes only the XABORT copy and marks it dirty. Memory receives nothing as a result of the store. A later transactional load of the same line returns the stored value.
- R4: A load that hits an XABORT entry returns its data, and a store that hits one overwrites it. Neither allocates or evicts anything.
- R5: `tx_commit` turns every XCOMMIT entry into EMPTY and every XABORT entry into NORMAL in one cycle. It causes no writeback.
- R6: `tx_abort` turns every XABORT entry into EMPTY and every XCOMMIT entry into NORMAL in one cycle. Abort wins over a simultaneous commit. A request in the same cycle as either strobe is dropped.
- R7: A transactional access that hits a NORMAL entry retags that entry XCOMMIT and places the working copy in one new XABORT entry. The new entry is dirty if the old one was dirty or the access is a store.
- R8: A victim is chosen from EMPTY entries first, then NORMAL, then XCOMMIT, taking the lowest index within a class. An XABORT entry is never chosen, and neither is the NORMAL entry being hit.
- R9: An evicted NORMAL or XCOMMIT entry that is dirty is written back one cycle after the request. The first victim uses lane 0 (`wb_*` bits of lane 0) and the second victim uses lane 1. Committed data reaches memory only this way.
- R10: If a request cannot obtain its victims (two on a miss, one on a NORMAL hit), `overflow` pulses one cycle later. The request has no other effect, and the abort retag of R6 is applied.
- R11: For any address, at most one entry tagged NORMAL or XABORT matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request strobe |
| req_op | input | 2 | 0 load, 1 load-exclusive, 2 store, 3 ignored |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Store data |
| tx_commit | input | 1 | Commit strobe |
| tx_abort | input | 1 | Abort strobe |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DATA_W | Load data |
| mem_rd_en | output | 1 | Refill read enable |
| mem_rd_addr | output | ADDR_W | Refill line address |
| mem_rd_data | input | DATA_W | Refill data, same cycle |
| wb_valid | output | 2 | Writeback valid per lane |
| wb_addr | output | 2*ADDR_W | Writeback addresses, lane k at bits k*ADDR_W |
| wb_data | output | 2*DATA_W | Writeback data, lane k at bits k*DATA_W |
| overflow | output | 1 | Capacity overflow pulse, transaction aborted |

## Verification
The bench builds the array with 8 entries, 8-bit line addresses and 32-bit data. With 8 entries, eight distinct misses inside one transaction exhaust the XCOMMIT victims, so the overflow path is reached. A handful of accesses is also enough to drive replacement through the EMPTY, NORMAL and XCOMMIT classes and to evict dirty committed lines on both writeback lanes. With the 256-line address space, a full behavioural memory sits in the bench and is compared at the end. A long random phase over twelve addresses mixes commit, abort and all four opcodes against the per-cycle model.

// File: rtl/txc_pkg.sv
package txc_pkg;

    typedef enum logic [1:0] {
        TS_EMPTY   = 2'd0,
        TS_NORMAL  = 2'd1,
        TS_XCOMMIT = 2'd2,
        TS_XABORT  = 2'd3
    } tstate_e;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_LOADX  = 2'd1,
        OP_STORE  = 2'd2,
        OP_IGNORE = 2'd3
    } txop_e;

    function automatic logic op_is_load(input logic [1:0] op);
        return (op == OP_LOAD) || (op == OP_LOADX);
    endfunction

    function automatic logic state_evictable(input tstate_e s);
        return (s == TS_NORMAL) || (s == TS_XCOMMIT);
    endfunction

endpackage

// File: rtl/txc_lookup.sv
module txc_lookup #(
    parameter int N  = 64,
    parameter int AW = 16,
    parameter int IW = 6
) (
    input  logic [N-1:0]    live,
    input  logic [N*AW-1:0] tags,
    input  logic [AW-1:0]   key,
    output logic [N-1:0]    match,
    output logic            hit,
    output logic [IW-1:0]   idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = live[g] && (tags[g*AW +: AW] == key);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/txc_victim.sv
module txc_victim #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  cand_empty,
    input  logic [N-1:0]  cand_normal,
    input  logic [N-1:0]  cand_xcommit,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0] pool;

    always_comb begin
        if (|cand_empty)       pool = cand_empty;
        else if (|cand_normal) pool = cand_normal;
        else                   pool = cand_xcommit;
        found = |pool;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pool[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/txc_cache.sv
module txc_cache
    import txc_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  tx_commit,
    input  logic                  tx_abort,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_data,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic [DATA_W-1:0]     mem_rd_data,
    output logic [1:0]            wb_valid,
    output logic [2*ADDR_W-1:0]   wb_addr,
    output logic [2*DATA_W-1:0]   wb_data,
    output logic                  overflow
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        tstate_e           st;
        logic              dirty;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t ent_q [ENTRIES];

    logic [ENTRIES-1:0]        m_emp, m_nrm, m_xc, m_xab;
    logic [ENTRIES*ADDR_W-1:0] tag_flat;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_mask
        assign m_emp[g] = (ent_q[g].st == TS_EMPTY);
        assign m_nrm[g] = (ent_q[g].st == TS_NORMAL);
        assign m_xc[g]  = (ent_q[g].st == TS_XCOMMIT);
        assign m_xab[g] = (ent_q[g].st == TS_XABORT);
        assign tag_flat[g*ADDR_W +: ADDR_W] = ent_q[g].addr;
    end

    // ---- associative search over resident copies
    logic [ENTRIES-1:0] match_vec;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;

    txc_lookup #(.N(ENTRIES), .AW(ADDR_W), .IW(IDX_W)) u_lookup (
        .live  (m_nrm | m_xab),
        .tags  (tag_flat),
        .key   (req_addr),
        .match (match_vec),
        .hit   (hit),
        .idx   (hit_idx)
    );

    logic hit_xab, hit_nrm;
    assign hit_xab = hit && (ent_q[hit_idx].st == TS_XABORT);
    assign hit_nrm = hit && (ent_q[hit_idx].st == TS_NORMAL);

    // ---- two chained victim pickers
    logic [ENTRIES-1:0] excl0, excl1;
    logic               vf0, vf1;
    logic [IDX_W-1:0]   vi0, vi1;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            excl0[i] = hit_nrm && (hit_idx == IDX_W'(i));
            excl1[i] = excl0[i] || (vf0 && (vi0 == IDX_W'(i)));
        end
    end

    txc_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim0 (
        .cand_empty   (m_emp & ~excl0),
        .cand_normal  (m_nrm & ~excl0),
        .cand_xcommit (m_xc  & ~excl0),
        .found        (vf0),
        .idx          (vi0)
    );

    txc_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim1 (
        .cand_empty   (m_emp & ~excl1),
        .cand_normal  (m_nrm & ~excl1),
        .cand_xcommit (m_xc  & ~excl1),
        .found        (vf1),
        .idx          (vi1)
    );

    // ---- request decode
    logic req_ok, is_st, need_ovf, force_abort, do_commit;
    logic [1:0] lane_use, ev_dirty;
    logic [DATA_W-1:0] load_val;

    assign req_ok      = req_valid && !tx_commit && !tx_abort && (req_op != OP_IGNORE);
    assign is_st       = (req_op == OP_STORE);
    assign need_ovf    = req_ok && ((hit_nrm && !vf0) || (!hit && !(vf0 && vf1)));
    assign force_abort = tx_abort || need_ovf;
    assign do_commit   = tx_commit && !tx_abort;
    assign lane_use[0] = req_ok && !need_ovf && !hit_xab;
    assign lane_use[1] = req_ok && !need_ovf && !hit;
    assign ev_dirty[0] = state_evictable(ent_q[vi0].st) && ent_q[vi0].dirty;
    assign ev_dirty[1] = state_evictable(ent_q[vi1].st) && ent_q[vi1].dirty;
    assign mem_rd_en   = req_ok && !hit;
    assign mem_rd_addr = req_addr;
    assign load_val    = hit ? ent_q[hit_idx].data : mem_rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= '{st: TS_EMPTY, dirty: 1'b0, addr: '0, data: '0};
            end
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            wb_valid  <= 2'b00;
            wb_addr   <= '0;
            wb_data   <= '0;
            overflow  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            wb_valid  <= 2'b00;
            overflow  <= need_ovf;
            if (force_abort) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (ent_q[i].st == TS_XABORT)  ent_q[i].st <= TS_EMPTY;
                    if (ent_q[i].st == TS_XCOMMIT) ent_q[i].st <= TS_NORMAL;
                end
            end else if (do_commit) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (ent_q[i].st == TS_XCOMMIT) ent_q[i].st <= TS_EMPTY;
                    if (ent_q[i].st == TS_XABORT)  ent_q[i].st <= TS_NORMAL;
                end
            end else if (req_ok) begin
                if (op_is_load(req_op)) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= load_val;
                end
                if (lane_use[0] && ev_dirty[0]) begin
                    wb_valid[0]          <= 1'b1;
                    wb_addr[0 +: ADDR_W] <= ent_q[vi0].addr;
                    wb_data[0 +: DATA_W] <= ent_q[vi0].data;
                end
                if (lane_use[1] && ev_dirty[1]) begin
                    wb_valid[1]               <= 1'b1;
                    wb_addr[ADDR_W +: ADDR_W] <= ent_q[vi1].addr;
                    wb_data[DATA_W +: DATA_W] <= ent_q[vi1].data;
                end
                if (hit_xab) begin
                    if (is_st) begin
                        ent_q[hit_idx].data  <= req_wdata;
                        ent_q[hit_idx].dirty <= 1'b1;
                    end
                end else if (hit_nrm) begin
                    ent_q[hit_idx].st <= TS_XCOMMIT;
                    ent_q[vi0] <= '{st: TS_XABORT,
                                    dirty: ent_q[hit_idx].dirty | is_st,
                                    addr: req_addr,
                                    data: is_st ? req_wdata : ent_q[hit_idx].data};
                end else begin
                    ent_q[vi0] <= '{st: TS_XCOMMIT, dirty: 1'b0,
                                    addr: req_addr, data: mem_rd_data};
                    ent_q[vi1] <= '{st: TS_XABORT, dirty: is_st,
                                    addr: req_addr,
                                    data: is_st ? req_wdata : mem_rd_data};
                end
            end
        end
    end

    // R11
    lookup_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    // R5
    commit_retag_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_commit && !tx_abort) |=> (m_xc == '0) && (wb_valid == 2'b00));

    // R6
    abort_retag_chk: assert property (@(posedge clk) disable iff (rst)
        tx_abort |=> (m_xab == '0) && !rsp_valid);

    // R10
    overflow_abort_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (m_xab == '0) && !rsp_valid && (wb_valid == 2'b00));

    // R3
    store_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !tx_commit && !tx_abort && hit_xab) |=> (wb_valid == 2'b00));

    // R8
    pair_bound_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(m_xc) <= $countones(m_xab));
endmodule

// File: tb/tb_txc_cache.sv
module tb_txc_cache;
    localparam int N = 8;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int CLK_PERIOD = 10;
    localparam int MSZ = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic tx_commit = 1'b0, tx_abort = 1'b0;
    logic rsp_valid, mem_rd_en, overflow;
    logic [DW-1:0] rsp_data, mem_rd_data;
    logic [AW-1:0] mem_rd_addr;
    logic [1:0] wb_valid;
    logic [2*AW-1:0] wb_addr;
    logic [2*DW-1:0] wb_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    txc_cache #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .tx_commit(tx_commit),
        .tx_abort(tx_abort), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .overflow(overflow)
    );

    // memory seen by the design and the model's own copy
    logic [DW-1:0] mem  [MSZ];
    logic [DW-1:0] mmem [MSZ];
    assign mem_rd_data = mem[mem_rd_addr];

    // model: 0 empty, 1 resident, 2 keep-on-abort (old), 3 keep-on-commit (new)
    int            m_st [N];
    logic [AW-1:0] m_ad [N];
    logic [DW-1:0] m_dt [N];
    bit            m_dr [N];

    bit            e_rv, e_ovf;
    logic [DW-1:0] e_rd;
    bit   [1:0]    e_wv;
    logic [AW-1:0] e_wa [2];
    logic [DW-1:0] e_wd [2];

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    function automatic logic [DW-1:0] init_val(input int a);
        return 32'hC0DE_0000 ^ (a * 32'h0001_0103);
    endfunction

    function automatic int choose(input int skip_a, input int skip_b);
        for (int cls = 0; cls < 3; cls++)
            for (int i = 0; i < N; i++)
                if (i != skip_a && i != skip_b && m_st[i] == cls) return i;
        return -1;
    endfunction

    task automatic evict(input int lane, input int v);
        if ((m_st[v] == 1 || m_st[v] == 2) && m_dr[v]) begin
            e_wv[lane] = 1'b1;
            e_wa[lane] = m_ad[v];
            e_wd[lane] = m_dt[v];
            mmem[m_ad[v]] = m_dt[v];
        end
    endtask

    task automatic model(input bit v, input bit [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input bit cm, input bit ab);
        bit ok, st_op, fab;
        int h;
        e_rv = 0; e_rd = '0; e_ovf = 0; e_wv = 2'b00;
        h = -1;
        for (int i = 0; i < N; i++)
            if ((m_st[i] == 1 || m_st[i] == 3) && m_ad[i] == a) h = i;
        ok = v && !cm && !ab && op != 2'd3;
        st_op = (op == 2'd2);
        fab = ab;
        if (ok) begin
            if (h >= 0 && m_st[h] == 3) begin
                if (st_op) begin m_dt[h] = wd; m_dr[h] = 1; end
                else begin e_rv = 1; e_rd = m_dt[h]; end
            end else if (h >= 0) begin
                int vv = choose(h, -1);
                if (vv < 0) begin e_ovf = 1; fab = 1; end
                else begin
                    if (!st_op) begin e_rv = 1; e_rd = m_dt[h]; end
                    evict(0, vv);
                    m_st[vv] = 3; m_ad[vv] = a;
                    m_dt[vv] = st_op ? wd : m_dt[h];
                    m_dr[vv] = m_dr[h] | st_op;
                    m_st[h] = 2;
                end
            end else begin
                int v0 = choose(-1, -1);
                int v1 = (v0 < 0) ? -1 : choose(v0, -1);
                if (v1 < 0) begin e_ovf = 1; fab = 1; end
                else begin
                    if (!st_op) begin e_rv = 1; e_rd = mmem[a]; end
                    evict(0, v0);
                    evict(1, v1);
                    m_st[v0] = 2; m_ad[v0] = a; m_dt[v0] = mmem[a]; m_dr[v0] = 0;
                    m_st[v1] = 3; m_ad[v1] = a; m_dt[v1] = st_op ? wd : mmem[a];
                    m_dr[v1] = st_op;
                end
            end
        end
        if (fab) begin
            for (int i = 0; i < N; i++) begin
                if (m_st[i] == 3) m_st[i] = 0;
                else if (m_st[i] == 2) m_st[i] = 1;
            end
        end else if (cm) begin
            for (int i = 0; i < N; i++) begin
                if (m_st[i] == 2) m_st[i] = 0;
                else if (m_st[i] == 3) m_st[i] = 1;
            end
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        check(cur_req, "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        if (e_rv) check(cur_req, "rsp_data", 64'(rsp_data), 64'(e_rd));
        check(cur_req, "overflow", 64'(overflow), 64'(e_ovf));
        check(cur_req, "wb_valid", 64'(wb_valid), 64'(e_wv));
        for (int k = 0; k < 2; k++) begin
            if (e_wv[k]) begin
                check(cur_req, "wb_addr", 64'(wb_addr[k*AW +: AW]), 64'(e_wa[k]));
                check(cur_req, "wb_data", 64'(wb_data[k*DW +: DW]), 64'(e_wd[k]));
            end
            if (wb_valid[k]) mem[wb_addr[k*AW +: AW]] = wb_data[k*DW +: DW];
        end
    endtask

    task automatic cyc(input bit v, input bit [1:0] op, input int a,
                       input logic [DW-1:0] wd, input bit cm, input bit ab);
        req_valid = v; req_op = op; req_addr = AW'(a); req_wdata = wd;
        tx_commit = cm; tx_abort = ab;
        model(v, op, AW'(a), wd, cm, ab);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; tx_commit = 0; tx_abort = 0;
        compare_outputs();
    endtask

    task automatic ld(input int a);          cyc(1, 2'd0, a, '0, 0, 0); endtask
    task automatic ldx(input int a);         cyc(1, 2'd1, a, '0, 0, 0); endtask
    task automatic st(input int a, input logic [DW-1:0] d); cyc(1, 2'd2, a, d, 0, 0); endtask
    task automatic commit_tx();              cyc(0, 2'd0, 0, '0, 1, 0); endtask
    task automatic abort_tx();               cyc(0, 2'd0, 0, '0, 0, 1); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL ALL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MSZ; i++) begin mem[i] = init_val(i); mmem[i] = init_val(i); end
        for (int i = 0; i < N; i++) begin m_st[i] = 0; m_ad[i] = '0; m_dt[i] = '0; m_dr[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        cur_req = "R1";
        check("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R1", "overflow after reset", 64'(overflow), 64'd0);
        check("R1", "wb_valid after reset", 64'(wb_valid), 64'd0);
        cyc(0, 2'd0, 0, '0, 0, 0);

        // R2 load miss, both load opcodes, ignored opcode
        cur_req = "R2";
        ld(1);
        check("R2", "load miss data", 64'(rsp_data), 64'(init_val(1)));
        ldx(2);
        check("R2", "load-exclusive miss data", 64'(rsp_data), 64'(init_val(2)));
        cyc(1, 2'd3, 4, 32'hDEAD_BEEF, 0, 0);
        check("R2", "ignored opcode no response", 64'(rsp_valid), 64'd0);

        // R3 / R4 store into working copy, hits on XABORT
        cur_req = "R3";
        st(1, 32'hAAAA_0001);
        check("R3", "store gives no writeback", 64'(wb_valid), 64'd0);
        cur_req = "R4";
        ld(1);
        check("R4", "load after store", 64'(rsp_data), 64'hAAAA_0001);
        st(1, 32'hAAAA_0002);
        ldx(1);
        check("R4", "second store visible", 64'(rsp_data), 64'hAAAA_0002);

        // R6 abort discards the working copy
        cur_req = "R6";
        abort_tx();
        ld(1);
        check("R6", "value restored by abort", 64'(rsp_data), 64'(init_val(1)));
        st(1, 32'h5555_0001);
        cyc(1, 2'd0, 1, '0, 1, 1);
        check("R6", "request beside strobes dropped", 64'(rsp_valid), 64'd0);
        ld(1);
        check("R6", "abort wins over commit", 64'(rsp_data), 64'(init_val(1)));

        // R5 commit keeps the working copy
        cur_req = "R5";
        st(3, 32'hBBBB_0003);
        commit_tx();
        check("R5", "commit no writeback", 64'(wb_valid), 64'd0);
        check("R5", "memory untouched by commit", 64'(mem[3]), 64'(init_val(3)));

        // R7 hit on resident line
        cur_req = "R7";
        ld(3);
        check("R7", "resident hit data", 64'(rsp_data), 64'hBBBB_0003);
        st(3, 32'hBBBB_0033);
        abort_tx();
        ld(3);
        check("R7", "old copy back after abort", 64'(rsp_data), 64'hBBBB_0003);
        commit_tx();

        // R8 / R9 replacement and dirty evictions
        cur_req = "R8";
        st(10, 32'h1010_1010);
        st(11, 32'h1111_1111);
        commit_tx();
        cur_req = "R9";
        for (int a = 20; a < 26; a++) ld(a);
        commit_tx();
        for (int a = 30; a < 36; a++) st(a, 32'h3000_0000 + 32'(a));
        commit_tx();
        for (int a = 40; a < 46; a++) ld(a);
        commit_tx();

        // R10 overflow after eight distinct misses in one transaction
        cur_req = "R10";
        for (int a = 50; a < 57; a++) begin
            ld(a);
            check("R10", "no early overflow", 64'(overflow), 64'd0);
        end
        ld(57);
        check("R10", "overflow on eighth miss", 64'(overflow), 64'd1);
        check("R10", "no data on overflow", 64'(rsp_valid), 64'd0);

        // random mix
        cur_req = "R11";
        for (int n = 0; n < 5000; n++) begin
            int r = $urandom_range(0, 99);
            int a = $urandom_range(0, 11);
            logic [DW-1:0] d = $urandom;
            if (r < 5)       commit_tx();
            else if (r < 9)  abort_tx();
            else if (r < 11) cyc(1, 2'($urandom_range(0, 3)), a, d, 1, 0);
            else if (r < 85) cyc(1, 2'($urandom_range(0, 3)), a, d, 0, 0);
            else             cyc(0, 2'd0, 0, '0, 0, 0);
        end

        // R9 memory image matches the model's writebacks
        for (int i = 0; i < MSZ; i++)
            if (mem[i] !== mmem[i]) check("R9", "memory image", 64'(mem[i]), 64'(mmem[i]));
        n_cmp++;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule